// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is an I2C target for a byte-wide register bus. It samples the bus clock and data lines with the system clock. It decides whether a transfer is aimed at it, then moves bytes between the bus and a simple register interface. Its 7-bit device address is a fixed three-bit prefix followed by two 2-bit select codes. Board strapping supplies each select code as one of four levels, so up to sixteen targets can share one bus.

In a write, the first byte after the address loads an internal register pointer. Every later byte is written to the register that the pointer selects. In a read, the first byte comes from wherever the pointer already points, so no command byte is needed. The pointer persists across transactions. After each byte moved it steps by one, and it stops at the top address of the 7-bit space. The data line is driven open-drain: the block either pulls it low or releases it.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The device address is `{1,0,0, sel_hi[1:0], sel_lo[1:0]}`. A matching address with the direction bit in bit 0 (0 = write, 1 = read) is acknowledged by pulling SDA low on the ninth clock. On a mismatch the block never pulls SDA low until the next START.
- R2: After reset, `sda_oe`, `reg_we` and `reg_re` are all 0.
- R3: In a write, the first byte after the address sets the pointer to its low 7 bits, and bit 7 is ignored. The pointer keeps this value when a STOP follows right away, and it is still in effect in later transactions.
- R4: Each data byte of a write produces one single-cycle `reg_we` pulse. During the pulse, `reg_addr` holds the pointer and `reg_wdata` holds the byte. The pulse occurs at the rising clock of that byte's acknowledge slot, while the block is acknowledging.
- R5: After each byte written or read, the pointer increases by one if it is below 0x7F. At 0x7F it stays at 0x7F.
- R6: A read returns the register at the stored pointer first, MSB first, and each byte produces exactly one `reg_re` pulse when it is fetched.
- R7: A repeated START between the pointer write and the read address is accepted, and the read begins at the newly written pointer.
- R8: After the master leaves a read byte unacknowledged, the block releases SDA and issues no further `reg_re` until the next START or STOP, even if the master keeps clocking.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect. In particular, a short opposite-level spike while SCL is high is not taken as a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_hi | input | 2 | Upper select code (device address bits 3:2) |
| sel_lo | input | 2 | Lower select code (device address bits 1:0) |
| reg_addr | output | 7 | Register address, equal to the pointer |
| reg_wdata | output | 8 | Write data for the register bus |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe, one per byte fetched |
| reg_rdata | input | 8 | Read data for `reg_addr`, valid in the same cycle |

## Verification
Each bus level reaches the core two synchronizer cycles, `FILT_LEN` filter cycles and one edge register after it settles at the pad. `reg_we`, `reg_re` and changes of `sda_oe` follow in the cycle the filtered SCL edge is seen, about 2 + `FILT_LEN` + 1 clocks after the pad edge. The bench holds every bus phase for 16 clocks, which is well beyond that delay. It samples SDA and the strobes in the middle of a phase, or logs strobes at the falling system-clock edge, so every result has settled before it is read.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    localparam int PTR_W = 7;
    localparam logic [PTR_W-1:0] PTR_MAX = '1;
    localparam logic [2:0] ADDR_PREFIX = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        BK_ADDR, BK_CMD, BK_DATA
    } bytekind_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [6:0] dev_addr(input logic [1:0] hi, input logic [1:0] lo);
        return {ADDR_PREFIX, hi, lo};
    endfunction

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_MAX) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2cx_glitch_filter.sv
module i2cx_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2, q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            q   <= 1'b1;
            cnt <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == q) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                q   <= s2;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign dout = q;

    // a filtered change needs the synchronized level held for at least two cycles
    AST_FILT_HELD: assert property (@(posedge clk) disable iff (rst)
        (q != $past(q)) |-> ($past(s2) == $past(s2, 2))); // R9

endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events
    import i2cx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lines_t  cur,
    output bus_ev_t ev
);
    lines_t prv;

    always_ff @(posedge clk) begin
        if (rst) prv <= '{scl: 1'b1, sda: 1'b1};
        else     prv <= cur;
    end

    always_comb begin
        ev.rise  = cur.scl & ~prv.scl;
        ev.fall  = ~cur.scl & prv.scl;
        ev.start = cur.scl & prv.scl & prv.sda & ~cur.sda;
        ev.stop  = cur.scl & prv.scl & ~prv.sda & cur.sda;
    end

endmodule

// File: rtl/i2cx_ptr_unit.sv
module i2cx_ptr_unit
    import i2cx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr_next(ptr);
    end

    AST_PTR_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && ptr == PTR_MAX) |=> (ptr == PTR_MAX)); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && ptr != PTR_MAX) |=> (ptr == $past(ptr) + 1'b1)); // R5
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (ptr == $past(load_val))); // R3

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2cx_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       sel_hi,
    input  logic [1:0]       sel_lo,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    output logic             reg_re,
    input  logic [7:0]       reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_v, filt_v;
    lines_t            filt;
    bus_ev_t           ev;

    assign raw_v = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            i2cx_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk (clk),
                .rst (rst),
                .din (raw_v[g]),
                .dout(filt_v[g])
            );
        end
    endgenerate

    assign filt = lines_t'(filt_v);

    i2cx_bus_events u_ev (
        .clk(clk),
        .rst(rst),
        .cur(filt),
        .ev (ev)
    );

    phase_e     st;
    bytekind_e  kind;
    logic       rd_mode, got8, mack_ok, drv;
    logic [2:0] bitcnt;
    logic [7:0] sh;
    logic [PTR_W-1:0] ptr;

    logic we_s, fetch_s, cmd_s;

    always_comb begin
        we_s    = (st == ST_ACK) && (kind == BK_DATA) && !rd_mode && ev.rise && !ev.start && !ev.stop;
        fetch_s = ev.fall && (((st == ST_ACK) && rd_mode) || ((st == ST_MACK) && mack_ok));
        cmd_s   = ev.fall && (st == ST_RX) && got8 && (kind == BK_CMD);
    end

    i2cx_ptr_unit u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd_s),
        .load_val(sh[PTR_W-1:0]),
        .inc     (we_s | fetch_s),
        .ptr     (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind    <= BK_ADDR;
            rd_mode <= 1'b0;
            got8    <= 1'b0;
            mack_ok <= 1'b0;
            drv     <= 1'b0;
            bitcnt  <= '0;
            sh      <= '0;
        end else if (ev.start) begin
            st      <= ST_RX;
            kind    <= BK_ADDR;
            rd_mode <= 1'b0;
            got8    <= 1'b0;
            drv     <= 1'b0;
            bitcnt  <= '0;
        end else if (ev.stop) begin
            st  <= ST_IDLE;
            drv <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (ev.rise && !got8) begin
                        sh     <= {sh[6:0], filt.sda};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) got8 <= 1'b1;
                    end
                    if (ev.fall && got8) begin
                        got8 <= 1'b0;
                        if (kind != BK_ADDR || sh[7:1] == dev_addr(sel_hi, sel_lo)) begin
                            st  <= ST_ACK;
                            drv <= 1'b1;
                            if (kind == BK_ADDR) rd_mode <= sh[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            st  <= ST_TX;
                            sh  <= reg_rdata;
                            drv <= ~reg_rdata[7];
                        end else begin
                            st   <= ST_RX;
                            drv  <= 1'b0;
                            kind <= (kind == BK_ADDR) ? BK_CMD : BK_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 3'd7) begin
                            st  <= ST_MACK;
                            drv <= 1'b0;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            drv    <= ~sh[6];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) mack_ok <= ~filt.sda;
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (mack_ok) begin
                            st  <= ST_TX;
                            sh  <= reg_rdata;
                            drv <= ~reg_rdata[7];
                        end else begin
                            st <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe    = drv;
    assign reg_addr  = ptr;
    assign reg_wdata = sh;
    assign reg_we    = we_s;
    assign reg_re    = fetch_s;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe); // R1
    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (!sda_oe && !reg_re)); // R8
    AST_WE_WHILE_ACK: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> sda_oe); // R4
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re})); // R6
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we); // R4

endmodule

// File: tb/sim_i2c_ptr_slave.sv
module sim_i2c_ptr_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, reg_we, reg_re;
    logic [1:0] sel_hi = 2'b00, sel_lo = 2'b00;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    wire sda_bus = sda_m & ~sda_oe;

    function automatic logic [7:0] rmem(input logic [6:0] a);
        return {a, 1'b0} ^ 8'h5C;
    endfunction
    assign reg_rdata = rmem(reg_addr);

    i2c_ptr_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int wr_n = 0, rd_n = 0;
    logic [6:0] wr_a [16];
    logic [7:0] wr_d [16];
    logic [6:0] rd_a [16];

    always @(negedge clk) begin
        if (!rst && reg_we) begin wr_a[wr_n % 16] = reg_addr; wr_d[wr_n % 16] = reg_wdata; wr_n++; end
        if (!rst && reg_re) begin rd_a[rd_n % 16] = reg_addr; rd_n++; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (16) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1; scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
    endtask
    task automatic i2c_rstart();
        sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
    endtask
    task automatic i2c_stop();
        sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1;
            if (glitch && i == 7) begin
                repeat (8) @(negedge clk); sda_m = ~sda_m;
                repeat (2) @(negedge clk); sda_m = ~sda_m;
                repeat (6) @(negedge clk);
            end else q();
            q(); scl_m = 0; q();
        end
        sda_m = 1; q(); scl_m = 1; q(); ack = (sda_bus === 1'b0); q(); scl_m = 0; q();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1; q(); b[i] = sda_bus; q(); scl_m = 0;
        end
        q(); sda_m = give_ack ? 1'b0 : 1'b1; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
    endtask

    // {sel_hi, sel_lo, address sent, command byte, data byte, ack expected}
    localparam int NV = 7;
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 2'b00, 7'h40, 8'h10, 8'h3C, 1'b1},
        {2'b01, 2'b10, 7'h46, 8'h85, 8'hA1, 1'b1},
        {2'b11, 2'b11, 7'h4F, 8'h7E, 8'h5A, 1'b1},
        {2'b10, 2'b01, 7'h49, 8'h22, 8'h77, 1'b1},
        {2'b10, 2'b01, 7'h48, 8'h22, 8'h77, 1'b0},
        {2'b00, 2'b11, 7'h43, 8'h01, 8'hF0, 1'b1},
        {2'b11, 2'b11, 7'h0F, 8'h11, 8'h99, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int w0, r0;
        repeat (5) @(negedge clk);
        chk("R2 sda_oe in reset", sda_oe, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk("R2 sda_oe after reset", sda_oe, 0);
        chk("R2 strobes after reset", {reg_we, reg_re}, 0);
        q();

        // table walk: R1 address match, R3 pointer from command, R4 write
        for (int v = 0; v < NV; v++) begin
            logic [27:0] t;
            t = VEC[v];
            sel_hi = t[27:26]; sel_lo = t[25:24];
            w0 = wr_n;
            i2c_start();
            send_byte({t[23:17], 1'b0}, 0, ack);
            chk($sformatf("R1 vec%0d address ack", v), ack, t[0]);
            send_byte(t[16:9], 0, ack);
            chk($sformatf("R1 vec%0d command ack", v), ack, t[0]);
            send_byte(t[8:1], 0, ack);
            i2c_stop();
            chk($sformatf("R4 vec%0d write count", v), wr_n - w0, t[0] ? 1 : 0);
            if (t[0]) begin
                chk($sformatf("R3 vec%0d write addr", v), wr_a[w0 % 16], t[15:9]);
                chk($sformatf("R4 vec%0d write data", v), wr_d[w0 % 16], t[8:1]);
            end
        end

        sel_hi = 2'b01; sel_lo = 2'b00; // device address 0x44

        // R5: burst write across the top of the pointer space
        w0 = wr_n;
        i2c_start();
        send_byte(8'h88, 0, ack);
        send_byte(8'h7D, 0, ack);
        for (int k = 0; k < 4; k++) send_byte(8'hC0 + 8'(k), 0, ack);
        i2c_stop();
        chk("R5 burst write count", wr_n - w0, 4);
        chk("R5 burst addr 0", wr_a[w0 % 16], 7'h7D);
        chk("R5 burst addr 1", wr_a[(w0 + 1) % 16], 7'h7E);
        chk("R5 burst addr 2", wr_a[(w0 + 2) % 16], 7'h7F);
        chk("R5 burst addr 3 saturated", wr_a[(w0 + 3) % 16], 7'h7F);
        chk("R4 burst data 3", wr_d[(w0 + 3) % 16], 8'hC3);

        // R5: read without command stays at 0x7F
        r0 = rd_n;
        i2c_start();
        send_byte(8'h89, 0, ack);
        recv_byte(1, b);
        chk("R5 read at saturated pointer", b, rmem(7'h7F));
        recv_byte(0, b);
        chk("R5 second read still 0x7F", b, rmem(7'h7F));
        i2c_stop();
        chk("R6 read strobe count", rd_n - r0, 2);

        // R3: command only, then STOP; R6 read from stored pointer; R8 NACK
        i2c_start();
        send_byte(8'h88, 0, ack);
        send_byte(8'hA0, 0, ack); // bit 7 ignored -> 0x20
        i2c_stop();
        r0 = rd_n;
        i2c_start();
        send_byte(8'h89, 0, ack);
        chk("R1 read address ack", ack, 1);
        recv_byte(1, b);
        chk("R6 first read byte", b, rmem(7'h20));
        recv_byte(0, b);
        chk("R6 second read byte", b, rmem(7'h21));
        chk("R6 read strobe addr", rd_a[(r0 + 1) % 16], 7'h21);
        recv_byte(0, b);
        chk("R8 bus released after NACK", b, 8'hFF);
        chk("R8 no fetch after NACK", rd_n - r0, 2);
        i2c_stop();

        // R3: pointer persists into a new transaction
        i2c_start();
        send_byte(8'h89, 0, ack);
        recv_byte(0, b);
        i2c_stop();
        chk("R3 pointer kept across transactions", b, rmem(7'h22));

        // R7: repeated start between pointer write and read
        r0 = rd_n;
        i2c_start();
        send_byte(8'h88, 0, ack);
        send_byte(8'h3E, 0, ack);
        i2c_rstart();
        send_byte(8'h89, 0, ack);
        chk("R7 read address ack after repeated start", ack, 1);
        recv_byte(1, b);
        chk("R7 first byte after repeated start", b, rmem(7'h3E));
        recv_byte(0, b);
        chk("R7 second byte after repeated start", b, rmem(7'h3F));
        i2c_stop();
        chk("R7 read strobe addr", rd_a[r0 % 16], 7'h3E);

        // R9: short spike on SDA while SCL is high must not end the transfer
        w0 = wr_n;
        i2c_start();
        send_byte(8'h88, 0, ack);
        send_byte(8'h30, 1, ack);
        chk("R9 command ack after spike", ack, 1);
        send_byte(8'h6B, 0, ack);
        i2c_stop();
        chk("R9 write survived spike", wr_n - w0, 1);
        chk("R9 write address after spike", wr_a[w0 % 16], 7'h30);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule